// File: doc/BRIEF.md
# Laser Current Level Selector

This block keeps the current-level settings for a laser driver and, on every clock, chooses the settings that go to the output DACs. Software loads byte-wide registers through a plain page/address/data write port. Two banks of eight write levels are stored, plus one read level. Each level is split into an upper byte and a lower byte. The line inputs (chip enable, active-low write enable, a 3-bit level code and a bank select) pick the operating mode and the level. The result is a registered 10-bit write code, a 12-bit read code, a mode value, a modulator-enable flag and a cooling flag.

Software can rewrite one bank while the other is driving the laser, and then switch banks with the bank select line. The 3-bit level code can arrive with unequal delays on its three lines. A hold filter therefore waits a programmable number of clocks after the first edge it sees before it samples the code again. As a result, only the old level and the new level ever reach the write code.

Top module: `laser_level_sel`

## Requirements
- R1: While chip_en is low, on the next clock mode is 0 (off), both codes are zero and both flags are low, whatever the other inputs are.
- R2: When chip_en is high and write mode is not granted, mode is 1 (read). In that case rd_code = {page 0 reg 19h, page 1 reg 09h bits [3:0]} when control register (page 0 reg 00h) bit 0 is set, and rd_code is zero when that bit is clear. The read level is the same for both banks.
- R3: Mode is 2 (write) only when chip_en is high, write_n is low and control bit 2 is set. In write mode wr_code = {page 0 reg A, page 2 reg A bits [1:0]}, where A is the level's address.
- R4: The bank 0 addresses for codes 0..7 are 10h, 04h, 06h, 08h, 0Ah, 0Ch, 0Eh, 12h. Each bank 1 address is the bank 0 address plus one.
- R5: bank_sel low selects bank 0 and bank_sel high selects bank 1. Writes to the bank that is not selected leave wr_code unchanged.
- R6: Page 1 reg 01h arms the modulator: bit 3 is the arm bit and bits [2:0] are the code. mod_en is high only in write mode when the filtered code equals that code and the arm bit is set.
- R7: Page 1 reg 02h sets the cooling code with the same layout as R6. cool_flag is high only in write mode when the filtered code matches and the arm bit is set.
- R8: Page 1 reg 03h bits [3:0] give the hold count H (reset value 2). The first code change seen at clock edge k is sampled at edge k+H, and the output shows it after edge k+H+1. Code changes inside that window produce no other level. With H = 0 the new level appears after edge k+1.
- R9: During reset all outputs are zero with mode 0. All registers clear to zero except the hold count.
- R10: A register write at edge e shows on the outputs after edge e+1, not after edge e.
- R11: wr_code is zero outside write mode. In write mode rd_code still follows R2, independently of the write selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_page | input | 2 | Register page |
| cfg_addr | input | 5 | Register address within page |
| cfg_wdata | input | 8 | Register write data |
| chip_en | input | 1 | Chip enable, high active |
| write_n | input | 1 | Write enable, low active |
| lvl_code | input | 3 | Write level code |
| bank_sel | input | 1 | Write bank select |
| wr_code | output | 10 | Selected write DAC code |
| rd_code | output | 12 | Read DAC code |
| mode | output | 2 | 0 off, 1 read, 2 write |
| mod_en | output | 1 | Modulator enable |
| cool_flag | output | 1 | Cooling level flag |

## Verification
The hardest situation to reach is a level-code transition whose three bits arrive on different clocks. To create it, the stimulus moves from code 3 to code 4 through 7 and 5, changing one line on each falling edge. It then samples wr_code on every cycle of the hold window and checks that only the W3 level appears until the exact cycle where W4 is due. The same transition with a hold count of zero confirms the one-cycle path. Writes to the idle bank made while the other bank is active show that the two banks are isolated.

// File: rtl/lls_pkg.sv
package lls_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_READ  = 2'd1,
      MODE_WRITE = 2'd2
   } lls_mode_e;

   localparam int CODE_W      = 3;
   localparam int CTRL_PAGE   = 0;
   localparam int CTRL_ADDR   = 0;
   localparam int CTRL_RD_BIT = 0;
   localparam int CTRL_WR_BIT = 2;
   localparam int RD_HI_PAGE  = 0;
   localparam int RD_HI_ADDR  = 'h19;
   localparam int RD_LO_PAGE  = 1;
   localparam int RD_LO_ADDR  = 'h09;
   localparam int WR_HI_PAGE  = 0;
   localparam int WR_LO_PAGE  = 2;
   localparam int OPT_PAGE    = 1;
   localparam int MOD_ADDR    = 1;
   localparam int COOL_ADDR   = 2;
   localparam int HOLD_ADDR   = 3;
   localparam int ARM_BIT     = 3;

   // base address of a level in bank 0; bank 1 sits one above
   function automatic int lvl_addr(input logic [CODE_W-1:0] code, input logic bank);
      int base;
      if (code == 3'd0)      base = 'h10;
      else if (code == 3'd7) base = 'h12;
      else                   base = 2 * int'(code) + 2;
      return base + int'(bank);
   endfunction

endpackage

// File: rtl/lls_regfile.sv
module lls_regfile #(
   parameter int DW       = 8,
   parameter int NPAGE    = 4,
   parameter int NADDR    = 32,
   parameter int HOLD_DEF = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(NPAGE)-1:0] page,
   input  logic [$clog2(NADDR)-1:0] addr,
   input  logic [DW-1:0]            wdata,
   output logic [DW-1:0]            regs_o [NPAGE][NADDR]
);
   import lls_pkg::*;

   logic [DW-1:0] regs_q [NPAGE][NADDR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NPAGE; p++) begin
            for (int a = 0; a < NADDR; a++) begin
               regs_q[p][a] <= (p == OPT_PAGE && a == HOLD_ADDR) ? DW'(HOLD_DEF) : '0;
            end
         end
      end else if (we) begin
         regs_q[page][addr] <= wdata;
      end
   end

   assign regs_o = regs_q;

endmodule

// File: rtl/lls_skew_hold.sv
module lls_skew_hold #(
   parameter int CW     = 3,
   parameter int HOLD_W = 4,
   parameter bit FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     code_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic [CW-1:0]     code_o
);

   generate
      if (FILTER) begin : g_filter
         logic [CW-1:0]     last_q;
         logic [CW-1:0]     code_q;
         logic [HOLD_W-1:0] cnt_q;
         logic              busy_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               last_q <= '0;
               code_q <= '0;
               cnt_q  <= '0;
               busy_q <= 1'b0;
            end else begin
               last_q <= code_i;
               if (busy_q) begin
                  if (cnt_q == '0) begin
                     code_q <= code_i;
                     busy_q <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                  end
               end else if (code_i != last_q) begin
                  if (hold_i == '0) begin
                     code_q <= code_i;
                  end else begin
                     busy_q <= 1'b1;
                     cnt_q  <= hold_i - 1'b1;
                  end
               end
            end
         end

         assign code_o = code_q;

         // R8
         hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && cnt_q != '0) |=> $stable(code_q));

         // R8
         first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy_q && code_i != last_q && hold_i != '0) |=> (busy_q && $stable(code_q)));
      end else begin : g_bypass
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, hold_i};
         assign code_o    = code_i;
      end
   endgenerate

endmodule

// File: rtl/lls_level_mux.sv
module lls_level_mux #(
   parameter int DW    = 8,
   parameter int NPAGE = 4,
   parameter int NADDR = 32,
   parameter int WR_W  = 10,
   parameter int RD_W  = 12
) (
   input  logic [DW-1:0]              regs_i [NPAGE][NADDR],
   input  logic                       chip_en,
   input  logic                       write_n,
   input  logic                       bank_sel,
   input  logic [lls_pkg::CODE_W-1:0] code,
   output lls_pkg::lls_mode_e         mode_d,
   output logic [WR_W-1:0]            wr_d,
   output logic [RD_W-1:0]            rd_d,
   output logic                       mod_d,
   output logic                       cool_d
);
   import lls_pkg::*;

   localparam int WR_LO = WR_W - DW;
   localparam int RD_LO = RD_W - DW;

   logic [DW-1:0] ctrl;
   logic [DW-1:0] mod_reg;
   logic [DW-1:0] cool_reg;
   logic [DW-1:0] wr_hi;
   logic [DW-1:0] wr_lo;
   logic          wr_ok;
   int            sel_a;

   always_comb begin
      ctrl     = regs_i[CTRL_PAGE][CTRL_ADDR];
      mod_reg  = regs_i[OPT_PAGE][MOD_ADDR];
      cool_reg = regs_i[OPT_PAGE][COOL_ADDR];
      sel_a    = lvl_addr(code, bank_sel);
      wr_hi    = regs_i[WR_HI_PAGE][sel_a];
      wr_lo    = regs_i[WR_LO_PAGE][sel_a];
      wr_ok    = chip_en && !write_n && ctrl[CTRL_WR_BIT];

      if (!chip_en)   mode_d = MODE_OFF;
      else if (wr_ok) mode_d = MODE_WRITE;
      else            mode_d = MODE_READ;

      wr_d = wr_ok ? {wr_hi, wr_lo[WR_LO-1:0]} : '0;

      if (chip_en && ctrl[CTRL_RD_BIT])
         rd_d = {regs_i[RD_HI_PAGE][RD_HI_ADDR], regs_i[RD_LO_PAGE][RD_LO_ADDR][RD_LO-1:0]};
      else
         rd_d = '0;

      mod_d  = wr_ok && mod_reg[ARM_BIT]  && (mod_reg[CODE_W-1:0]  == code);
      cool_d = wr_ok && cool_reg[ARM_BIT] && (cool_reg[CODE_W-1:0] == code);
   end

endmodule

// File: rtl/laser_level_sel.sv
module laser_level_sel #(
   parameter int DW          = 8,
   parameter int NPAGE       = 4,
   parameter int NADDR       = 32,
   parameter int WR_W        = 10,
   parameter int RD_W        = 12,
   parameter int HOLD_W      = 4,
   parameter int HOLD_DEF    = 2,
   parameter bit SKEW_FILTER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [$clog2(NPAGE)-1:0] cfg_page,
   input  logic [$clog2(NADDR)-1:0] cfg_addr,
   input  logic [DW-1:0]            cfg_wdata,
   input  logic                     chip_en,
   input  logic                     write_n,
   input  logic [2:0]               lvl_code,
   input  logic                     bank_sel,
   output logic [WR_W-1:0]          wr_code,
   output logic [RD_W-1:0]          rd_code,
   output logic [1:0]               mode,
   output logic                     mod_en,
   output logic                     cool_flag
);
   import lls_pkg::*;

   localparam int WR_LO = WR_W - DW;
   localparam int RD_LO = RD_W - DW;

   generate
      if (NPAGE < 3)                   begin : g_bad_page  $error("NPAGE must be at least 3"); end
      if (NADDR <= RD_HI_ADDR)         begin : g_bad_addr  $error("NADDR too small for map"); end
      if (WR_LO < 1 || WR_LO > DW)     begin : g_bad_wr    $error("WR_W out of range"); end
      if (RD_LO < 1 || RD_LO > DW)     begin : g_bad_rd    $error("RD_W out of range"); end
      if (HOLD_W > DW)                 begin : g_bad_hw    $error("HOLD_W wider than a register"); end
      if (HOLD_DEF >= (1 << HOLD_W))   begin : g_bad_hdef  $error("HOLD_DEF does not fit"); end
   endgenerate

   logic [DW-1:0]     regs [NPAGE][NADDR];
   logic [CODE_W-1:0] code_f;
   logic [HOLD_W-1:0] hold_cnt;
   lls_mode_e         mode_d;
   logic [WR_W-1:0]   wr_d;
   logic [RD_W-1:0]   rd_d;
   logic              mod_d;
   logic              cool_d;

   lls_regfile #(
      .DW(DW), .NPAGE(NPAGE), .NADDR(NADDR), .HOLD_DEF(HOLD_DEF)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .page(cfg_page),
      .addr(cfg_addr), .wdata(cfg_wdata), .regs_o(regs)
   );

   assign hold_cnt = regs[OPT_PAGE][HOLD_ADDR][HOLD_W-1:0];

   lls_skew_hold #(
      .CW(CODE_W), .HOLD_W(HOLD_W), .FILTER(SKEW_FILTER)
   ) i_skew (
      .clk(clk), .rst_n(rst_n), .code_i(lvl_code), .hold_i(hold_cnt), .code_o(code_f)
   );

   lls_level_mux #(
      .DW(DW), .NPAGE(NPAGE), .NADDR(NADDR), .WR_W(WR_W), .RD_W(RD_W)
   ) i_mux (
      .regs_i(regs), .chip_en(chip_en), .write_n(write_n), .bank_sel(bank_sel),
      .code(code_f), .mode_d(mode_d), .wr_d(wr_d), .rd_d(rd_d),
      .mod_d(mod_d), .cool_d(cool_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_code   <= '0;
         rd_code   <= '0;
         mode      <= MODE_OFF;
         mod_en    <= 1'b0;
         cool_flag <= 1'b0;
      end else begin
         wr_code   <= wr_d;
         rd_code   <= rd_d;
         mode      <= mode_d;
         mod_en    <= mod_d;
         cool_flag <= cool_d;
      end
   end

   // R1
   off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> (mode == MODE_OFF && wr_code == '0 && rd_code == '0 && !mod_en && !cool_flag));

   // R3
   write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WRITE) |-> ($past(chip_en) && !$past(write_n)));

   // R6
   flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en || cool_flag) |-> (mode == MODE_WRITE));

   // R11
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_WRITE) |-> (wr_code == '0));

endmodule

// File: tb/test_laser_level_sel.sv
module test_laser_level_sel;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_page;
   logic [4:0]  cfg_addr;
   logic [7:0]  cfg_wdata;
   logic        chip_en;
   logic        write_n;
   logic [2:0]  lvl_code;
   logic        bank_sel;
   logic [9:0]  wr_code;
   logic [11:0] rd_code;
   logic [1:0]  mode;
   logic        mod_en;
   logic        cool_flag;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   laser_level_sel i_laser_level_sel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .chip_en(chip_en),
      .write_n(write_n), .lvl_code(lvl_code), .bank_sel(bank_sel),
      .wr_code(wr_code), .rd_code(rd_code), .mode(mode),
      .mod_en(mod_en), .cool_flag(cool_flag)
   );

   function automatic logic [4:0] addr_of(input logic [2:0] c, input logic b);
      logic [4:0] a;
      case (c)
         3'd0: a = 5'h10;
         3'd1: a = 5'h04;
         3'd2: a = 5'h06;
         3'd3: a = 5'h08;
         3'd4: a = 5'h0A;
         3'd5: a = 5'h0C;
         3'd6: a = 5'h0E;
         default: a = 5'h12;
      endcase
      return a | {4'b0, b};
   endfunction

   function automatic logic [7:0] hi_of(input logic [2:0] c, input logic b);
      return {b, c, 4'h5};
   endfunction

   function automatic logic [7:0] lo_of(input logic [2:0] c, input logic b);
      return {4'hF, 2'b00, c[0] ^ b, c[1]};
   endfunction

   function automatic logic [9:0] exp_wr(input logic [2:0] c, input logic b);
      logic [7:0] lo;
      lo = lo_of(c, b);
      return {hi_of(c, b), lo[1:0]};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] p, input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_page = p; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cfg_we = 1'b0; cfg_page = '0; cfg_addr = '0; cfg_wdata = '0;
      chip_en = 1'b1; write_n = 1'b0; lvl_code = 3'd5; bank_sel = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "mode in reset", 32'(mode), 0);
      chk("R9", "codes in reset", 32'({wr_code, rd_code}), 0);
      chk("R9", "flags in reset", 32'({mod_en, cool_flag}), 0);
      rst_n = 1'b1;
      settle();
      // registers cleared: control bit 2 clear -> read mode, read disabled
      chk("R9", "mode after reset", 32'(mode), 1);
      chk("R9", "rd after reset", 32'(rd_code), 0);
   endtask

   task automatic load_levels();
      for (int b = 0; b < 2; b++) begin
         for (int c = 0; c < 8; c++) begin
            wreg(2'd0, addr_of(3'(c), 1'(b)), hi_of(3'(c), 1'(b)));
            wreg(2'd2, addr_of(3'(c), 1'(b)), lo_of(3'(c), 1'(b)));
         end
      end
      wreg(2'd0, 5'h19, 8'hC3);
      wreg(2'd1, 5'h09, 8'hFA);
      wreg(2'd0, 5'h00, 8'h05);
   endtask

   task automatic t_off();
      chip_en = 1'b0; write_n = 1'b0; lvl_code = 3'd2;
      settle();
      chk("R1", "off mode", 32'(mode), 0);
      chk("R1", "off codes", 32'({wr_code, rd_code}), 0);
      chk("R1", "off flags", 32'({mod_en, cool_flag}), 0);
      chip_en = 1'b1;
   endtask

   task automatic t_read();
      write_n = 1'b1; bank_sel = 1'b0;
      settle();
      chk("R2", "read mode", 32'(mode), 1);
      chk("R2", "read code bank0", 32'(rd_code), 32'h0C3A);
      chk("R11", "wr idle in read", 32'(wr_code), 0);
      bank_sel = 1'b1;
      settle();
      chk("R2", "read code bank1", 32'(rd_code), 32'h0C3A);
      wreg(2'd0, 5'h00, 8'h04);
      settle();
      chk("R2", "read disabled", 32'(rd_code), 0);
      wreg(2'd0, 5'h00, 8'h01);
      write_n = 1'b0;
      settle();
      chk("R3", "write bit clear gives read", 32'(mode), 1);
      chk("R11", "wr zero when write bit clear", 32'(wr_code), 0);
      wreg(2'd0, 5'h00, 8'h05);
   endtask

   task automatic t_write();
      write_n = 1'b0;
      for (int b = 0; b < 2; b++) begin
         for (int c = 0; c < 8; c++) begin
            bank_sel = 1'(b); lvl_code = 3'(c);
            settle();
            chk("R3", "write mode", 32'(mode), 2);
            chk(b ? "R5" : "R4", "write level", 32'(wr_code), 32'(exp_wr(3'(c), 1'(b))));
         end
      end
      chk("R11", "read alongside write", 32'(rd_code), 32'h0C3A);
   endtask

   task automatic t_bank_iso();
      bank_sel = 1'b0; lvl_code = 3'd5;
      settle();
      wreg(2'd0, 5'h0D, 8'h11);
      wreg(2'd2, 5'h0D, 8'h02);
      settle();
      chk("R5", "idle bank write no effect", 32'(wr_code), 32'(exp_wr(3'd5, 1'b0)));
      wreg(2'd0, 5'h0C, 8'hE7);
      chk("R10", "not after write edge", 32'(wr_code), 32'(exp_wr(3'd5, 1'b0)));
      @(posedge clk); @(negedge clk);
      chk("R10", "after second edge", 32'(wr_code), 32'({8'hE7, 2'b10}));
      bank_sel = 1'b1;
      settle();
      chk("R5", "bank1 shows new value", 32'(wr_code), 32'({8'h11, 2'b10}));
      wreg(2'd0, 5'h0C, hi_of(3'd5, 1'b0));
      wreg(2'd0, 5'h0D, hi_of(3'd5, 1'b1));
      wreg(2'd2, 5'h0D, lo_of(3'd5, 1'b1));
      bank_sel = 1'b0;
   endtask

   task automatic t_mod_cool();
      wreg(2'd1, 5'h01, 8'h0E);
      wreg(2'd1, 5'h02, 8'h09);
      write_n = 1'b0; lvl_code = 3'd6;
      settle();
      chk("R6", "mod on code 6", 32'({mod_en, cool_flag}), 32'b10);
      lvl_code = 3'd1;
      settle();
      chk("R7", "cool on code 1", 32'({mod_en, cool_flag}), 32'b01);
      lvl_code = 3'd3;
      settle();
      chk("R6", "no flag code 3", 32'({mod_en, cool_flag}), 0);
      lvl_code = 3'd6; write_n = 1'b1;
      settle();
      chk("R6", "no mod in read", 32'(mod_en), 0);
      write_n = 1'b0;
      wreg(2'd1, 5'h01, 8'h06);
      settle();
      chk("R6", "mod disarmed", 32'(mod_en), 0);
      lvl_code = 3'd1;
      wreg(2'd1, 5'h02, 8'h01);
      settle();
      chk("R7", "cool disarmed", 32'(cool_flag), 0);
   endtask

   task automatic t_skew();
      write_n = 1'b0; bank_sel = 1'b0; lvl_code = 3'd3;
      settle();
      chk("R8", "start level", 32'(wr_code), 32'(exp_wr(3'd3, 1'b0)));
      lvl_code = 3'b111;
      @(posedge clk); @(negedge clk);
      chk("R8", "hold edge k", 32'(wr_code), 32'(exp_wr(3'd3, 1'b0)));
      lvl_code = 3'b101;
      @(posedge clk); @(negedge clk);
      chk("R8", "hold edge k+1", 32'(wr_code), 32'(exp_wr(3'd3, 1'b0)));
      lvl_code = 3'b100;
      @(posedge clk); @(negedge clk);
      chk("R8", "hold edge k+2", 32'(wr_code), 32'(exp_wr(3'd3, 1'b0)));
      @(posedge clk); @(negedge clk);
      chk("R8", "new level edge k+3", 32'(wr_code), 32'(exp_wr(3'd4, 1'b0)));
      settle();
      chk("R8", "new level steady", 32'(wr_code), 32'(exp_wr(3'd4, 1'b0)));
   endtask

   task automatic t_hold0();
      wreg(2'd1, 5'h03, 8'h00);
      lvl_code = 3'd2;
      @(posedge clk); @(negedge clk);
      chk("R8", "hold0 edge k", 32'(wr_code), 32'(exp_wr(3'd4, 1'b0)));
      @(posedge clk); @(negedge clk);
      chk("R8", "hold0 edge k+1", 32'(wr_code), 32'(exp_wr(3'd2, 1'b0)));
      wreg(2'd1, 5'h03, 8'h02);
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      load_levels();
      t_off();
      t_read();
      t_write();
      t_bank_iso();
      t_mod_cool();
      t_skew();
      t_hold0();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule